// File: doc/BRIEF.md
# Hashed Binary-Tree Walk Engine

This engine moves a batch of walkers across an implicit complete binary tree kept in word-addressed memory, for a configured number of rounds. The tree's node values sit in one flat array in breadth-first order, with the root at position 0. Each walker has a current node position and a 32-bit value. At every step the walker mixes its value with the value of its current node, hashes the result, and uses the parity of the new value to choose a child. A walker that falls below the last node goes back to the root.

The engine takes all of its configuration from a small header at the start of memory, so software only has to lay out memory and pulse `start`. It uses a single synchronous memory port with one cycle of read latency. The hash is computed in a registered pipeline with one register per mixing stage. When all rounds are done, the engine pulses `done` for one cycle.

Top module: `tree_walk_engine`

## Requirements
- R1: After `start` is accepted, the engine reads its configuration from word addresses 0 to 6 in ascending order. The words are: 0 = round count, 1 = node count, 2 = batch size, 3 = tree depth (read but not used), 4 = base of the node-value array, 5 = base of the position array, 6 = base of the value array.
- R2: A walker's new value is H(value XOR node[position]). H applies six stages to a 32-bit word x, mod 2^32, in this order: (x+7ED55D16h)+(x<<12); (x^C761C23Ch)^(x>>19); (x+165667B1h)+(x<<5); (x+D3A2646Ch)^(x<<9); (x+FD7046C5h)+(x<<3); (x^B55A4F09h)^(x>>16).
- R3: The next position is 2*position+1 when the new value is even, and 2*position+2 when it is odd.
- R4: A next position that is greater than or equal to the node count is replaced by 0, so every position written lies below the node count.
- R5: Within a round, walkers are handled in ascending order, and each round completes before the next begins. For each walker the engine writes the new position to position base + walker, and then the new value to value base + walker.
- R6: `done` is high for exactly one cycle, in the cycle right after the final value write. `busy` is low in that cycle.
- R7: A round count of 0 or a batch size of 0 ends the run after the header reads with a `done` pulse and no memory write. While idle, the engine makes no memory access.
- R8: `start` is ignored while `busy` is high: the run in progress is unaffected, and no second run follows it.
- R9: Read data is taken on the cycle after `mem_rd_en`. A read and a write never share a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run when idle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| mem_rd_en | output | 1 | Memory read request |
| mem_wr_en | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |

## Verification
The checker watches the port protocol on every cycle. It confirms that reads and writes never overlap, that `done` lasts one cycle and only appears when the engine is idle, and that the engine is quiet while idle. It also confirms that every position written is already wrapped below the node count, and that a run starts only from a `start` request. The hash values, the branch choices, the walker and round ordering, the header decode at arbitrary array bases, and the zero-round and ignored-start cases can only be shown by the bench scenarios. The bench compares the final memory image and the full write sequence against its own model of the walk.

// File: rtl/twe_pkg.sv
package twe_pkg;
  localparam int WORD_W   = 32;
  localparam int N_HSTAGE = 6;
  localparam int HDR_LAST = 6;

  typedef logic [WORD_W-1:0] word_t;

  // One mixing stage: r = (x op_a K) op_b (x shift S)
  typedef struct packed {
    logic        a_add;   // 1: x + K, 0: x ^ K
    logic [31:0] k;
    logic        b_add;   // 1: combine by add, 0: by xor
    logic        left;    // 1: shift left, 0: shift right
    logic [4:0]  sh;
  } hstage_t;

  function automatic hstage_t stage_cfg(input int i);
    hstage_t c;
    case (i)
      0:       c = '{1'b1, 32'h7ED55D16, 1'b1, 1'b1, 5'd12};
      1:       c = '{1'b0, 32'hC761C23C, 1'b0, 1'b0, 5'd19};
      2:       c = '{1'b1, 32'h165667B1, 1'b1, 1'b1, 5'd5};
      3:       c = '{1'b1, 32'hD3A2646C, 1'b0, 1'b1, 5'd9};
      4:       c = '{1'b1, 32'hFD7046C5, 1'b1, 1'b1, 5'd3};
      default: c = '{1'b0, 32'hB55A4F09, 1'b0, 1'b0, 5'd16};
    endcase
    return c;
  endfunction

  typedef enum logic [3:0] {
    ST_IDLE, ST_HREQ, ST_HCAP, ST_RIDX, ST_RVAL, ST_RNODE,
    ST_HLAUNCH, ST_HWAIT, ST_WIDX, ST_WVAL
  } state_t;
endpackage

// File: rtl/twe_hash_stage.sv
module twe_hash_stage #(
  parameter int IDX = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_v,
  input  twe_pkg::word_t      in_d,
  output logic                out_v,
  output twe_pkg::word_t      out_d
);
  localparam twe_pkg::hstage_t CFG = twe_pkg::stage_cfg(IDX);

  twe_pkg::word_t t_const, t_shift, t_mix;

  always_comb begin
    t_const = CFG.a_add ? (in_d + CFG.k) : (in_d ^ CFG.k);
    t_shift = CFG.left  ? (in_d << CFG.sh) : (in_d >> CFG.sh);
    t_mix   = CFG.b_add ? (t_const + t_shift) : (t_const ^ t_shift);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_v <= 1'b0;
      out_d <= '0;
    end else begin
      out_v <= in_v;
      out_d <= t_mix;
    end
  end
endmodule

// File: rtl/twe_hash_pipe.sv
module twe_hash_pipe #(
  parameter int STAGES = twe_pkg::N_HSTAGE
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_v,
  input  twe_pkg::word_t in_d,
  output logic           out_v,
  output twe_pkg::word_t out_d
);
  logic           v [0:STAGES];
  twe_pkg::word_t d [0:STAGES];

  assign v[0] = in_v;
  assign d[0] = in_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    twe_hash_stage #(.IDX(g)) u_stage (
      .clk  (clk),
      .rst  (rst),
      .in_v (v[g]),
      .in_d (d[g]),
      .out_v(v[g+1]),
      .out_d(d[g+1])
    );
  end

  assign out_v = v[STAGES];
  assign out_d = d[STAGES];
endmodule

// File: rtl/twe_ctrl.sv
module twe_ctrl #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output twe_pkg::word_t    mem_wdata,
  input  twe_pkg::word_t    mem_rdata,
  output logic              hash_in_v,
  output twe_pkg::word_t    hash_in_d,
  input  logic              hash_out_v,
  input  twe_pkg::word_t    hash_out_d,
  output twe_pkg::word_t    node_cnt,
  output logic              idx_wr
);
  import twe_pkg::*;
  localparam int W = WORD_W;

  state_t            state_q;
  logic [2:0]        hcnt_q;
  word_t             rounds_q, nodes_q, round_q;
  logic [ADDR_W-1:0] batch_q, walker_q;
  logic [ADDR_W-1:0] node_base_q, idx_base_q, val_base_q;
  word_t             cur_idx_q, cur_val_q, new_val_q;

  logic [W:0]        cand;
  word_t             nxt_idx;
  logic              last_w, last_r;
  logic [ADDR_W-1:0] nxt_walker;

  always_comb begin
    cand       = {cur_idx_q, 1'b0} + ((W+1)'(hash_out_d[0] ? 2 : 1));
    nxt_idx    = (cand >= {1'b0, nodes_q}) ? '0 : cand[W-1:0];
    last_w     = (walker_q == batch_q - ADDR_W'(1));
    last_r     = (round_q == rounds_q - 1);
    nxt_walker = last_w ? '0 : walker_q + ADDR_W'(1);
  end

  assign busy      = (state_q != ST_IDLE);
  assign hash_in_v = (state_q == ST_HLAUNCH);
  assign hash_in_d = cur_val_q ^ mem_rdata;
  assign node_cnt  = nodes_q;
  assign idx_wr    = (state_q == ST_WIDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      hcnt_q      <= '0;
      done        <= 1'b0;
      mem_rd_en   <= 1'b0;
      mem_wr_en   <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      rounds_q    <= '0;
      nodes_q     <= '0;
      round_q     <= '0;
      batch_q     <= '0;
      walker_q    <= '0;
      node_base_q <= '0;
      idx_base_q  <= '0;
      val_base_q  <= '0;
      cur_idx_q   <= '0;
      cur_val_q   <= '0;
      new_val_q   <= '0;
    end else begin
      mem_rd_en <= 1'b0;
      mem_wr_en <= 1'b0;
      done      <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            mem_rd_en <= 1'b1;
            mem_addr  <= '0;
            hcnt_q    <= '0;
            state_q   <= ST_HREQ;
          end
        end
        ST_HREQ: state_q <= ST_HCAP;
        ST_HCAP: begin
          case (hcnt_q)
            3'd0:    rounds_q    <= mem_rdata;
            3'd1:    nodes_q     <= mem_rdata;
            3'd2:    batch_q     <= mem_rdata[ADDR_W-1:0];
            3'd4:    node_base_q <= mem_rdata[ADDR_W-1:0];
            3'd5:    idx_base_q  <= mem_rdata[ADDR_W-1:0];
            3'd6:    val_base_q  <= mem_rdata[ADDR_W-1:0];
            default: ;
          endcase
          if (hcnt_q == 3'(HDR_LAST)) begin
            walker_q <= '0;
            round_q  <= '0;
            if (rounds_q == '0 || batch_q == '0) begin
              done    <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              mem_rd_en <= 1'b1;
              mem_addr  <= idx_base_q;
              state_q   <= ST_RIDX;
            end
          end else begin
            hcnt_q    <= hcnt_q + 3'd1;
            mem_rd_en <= 1'b1;
            mem_addr  <= ADDR_W'(hcnt_q) + ADDR_W'(1);
            state_q   <= ST_HREQ;
          end
        end
        ST_RIDX: begin
          mem_rd_en <= 1'b1;
          mem_addr  <= val_base_q + walker_q;
          state_q   <= ST_RVAL;
        end
        ST_RVAL: begin
          cur_idx_q <= mem_rdata;
          mem_rd_en <= 1'b1;
          mem_addr  <= node_base_q + mem_rdata[ADDR_W-1:0];
          state_q   <= ST_RNODE;
        end
        ST_RNODE: begin
          cur_val_q <= mem_rdata;
          state_q   <= ST_HLAUNCH;
        end
        ST_HLAUNCH: state_q <= ST_HWAIT;
        ST_HWAIT: begin
          if (hash_out_v) begin
            new_val_q <= hash_out_d;
            mem_wr_en <= 1'b1;
            mem_addr  <= idx_base_q + walker_q;
            mem_wdata <= nxt_idx;
            state_q   <= ST_WIDX;
          end
        end
        ST_WIDX: begin
          mem_wr_en <= 1'b1;
          mem_addr  <= val_base_q + walker_q;
          mem_wdata <= new_val_q;
          state_q   <= ST_WVAL;
        end
        ST_WVAL: begin
          walker_q <= nxt_walker;
          if (last_w && last_r) begin
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            if (last_w) round_q <= round_q + 1;
            mem_rd_en <= 1'b1;
            mem_addr  <= idx_base_q + nxt_walker;
            state_q   <= ST_RIDX;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tree_walk_engine.sv
module tree_walk_engine #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata
);
  twe_pkg::word_t h_in_d, h_out_d, node_cnt;
  logic           h_in_v, h_out_v, idx_wr;

  twe_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .hash_in_v (h_in_v),
    .hash_in_d (h_in_d),
    .hash_out_v(h_out_v),
    .hash_out_d(h_out_d),
    .node_cnt  (node_cnt),
    .idx_wr    (idx_wr)
  );

  twe_hash_pipe #(.STAGES(twe_pkg::N_HSTAGE)) u_hash (
    .clk  (clk),
    .rst  (rst),
    .in_v (h_in_v),
    .in_d (h_in_d),
    .out_v(h_out_v),
    .out_d(h_out_d)
  );
endmodule

// File: rtl/tree_walk_engine_chk.sv
module tree_walk_engine_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              mem_rd_en,
  input logic              mem_wr_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic [31:0]       node_cnt,
  input logic              idx_wr
);
  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && mem_wr_en)); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R6

  AST_IDX_WRAPPED: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_en && idx_wr) |-> (mem_wdata < node_cnt)); // R4

  AST_RUN_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_rd_en && !mem_wr_en)); // R7
endmodule

bind tree_walk_engine tree_walk_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .mem_rd_en(mem_rd_en),
  .mem_wr_en(mem_wr_en),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata),
  .node_cnt (node_cnt),
  .idx_wr   (idx_wr)
);

// File: tb/tree_walk_engine_tb.sv
module tree_walk_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int MEM_N = 256;
  localparam int LOG_N = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic busy, done, mem_rd_en, mem_wr_en;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  logic [31:0] mem     [0:MEM_N-1];
  logic [31:0] exp_mem [0:MEM_N-1];
  int exp_wa [0:LOG_N-1];
  logic [31:0] exp_wd [0:LOG_N-1];
  int act_wa [0:LOG_N-1];
  logic [31:0] act_wd [0:LOG_N-1];
  int rd_log [0:7];
  int n_exp, n_wr, n_rd, n_done, n_conf;
  int cyc, last_wr_cyc, done_cyc;
  int n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tree_walk_engine #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_wr_en) mem[mem_addr[7:0]] <= mem_wdata;
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (mem_wr_en && n_wr < LOG_N) begin
      act_wa[n_wr] = int'(mem_addr);
      act_wd[n_wr] = mem_wdata;
      n_wr = n_wr + 1;
      last_wr_cyc = cyc;
    end
    if (mem_rd_en && n_rd < 8) begin
      rd_log[n_rd] = int'(mem_addr);
      n_rd = n_rd + 1;
    end
    if (mem_rd_en && mem_wr_en) n_conf = n_conf + 1;
    if (done) begin
      n_done = n_done + 1;
      done_cyc = cyc;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] mix(input logic [31:0] a);
    a = (a + 32'h7ED55D16) + (a << 12);
    a = (a ^ 32'hC761C23C) ^ (a >> 19);
    a = (a + 32'h165667B1) + (a << 5);
    a = (a + 32'hD3A2646C) ^ (a << 9);
    a = (a + 32'hFD7046C5) + (a << 3);
    a = (a ^ 32'hB55A4F09) ^ (a >> 16);
    return a;
  endfunction

  // lay out memory and compute the expected walk
  task automatic build(input int rounds, input int height, input int batch);
    int nodes, nb, ib, vb;
    nodes = (1 << (height + 1)) - 1;
    nb = 16 + int'($urandom % 8);
    ib = nb + nodes + int'($urandom % 4);
    vb = ib + batch + int'($urandom % 4);
    for (int i = 0; i < MEM_N; i++) mem[i] = $urandom;
    mem[0] = rounds; mem[1] = nodes; mem[2] = batch; mem[3] = height;
    mem[4] = nb; mem[5] = ib; mem[6] = vb;
    for (int i = 0; i < nodes; i++) mem[nb+i] = $urandom & 32'h3FFFFFFF;
    for (int i = 0; i < batch; i++) begin
      mem[ib+i] = 0;
      mem[vb+i] = $urandom & 32'h3FFFFFFF;
    end
    for (int i = 0; i < MEM_N; i++) exp_mem[i] = mem[i];
    n_exp = 0;
    for (int r = 0; r < rounds; r++)
      for (int w = 0; w < batch; w++) begin
        logic [31:0] p, v;
        p = exp_mem[ib+w];
        v = mix(exp_mem[vb+w] ^ exp_mem[nb+p]);
        p = 2*p + (v[0] ? 2 : 1);
        if (p >= nodes) p = 0;
        exp_mem[ib+w] = p;
        exp_mem[vb+w] = v;
        exp_wa[n_exp] = ib+w; exp_wd[n_exp] = p; n_exp++;
        exp_wa[n_exp] = vb+w; exp_wd[n_exp] = v; n_exp++;
      end
  endtask

  task automatic run(input string nm, input bit extra_start);
    int waited, bad_mem, bad_seq;
    n_wr = 0; n_rd = 0; n_done = 0; n_conf = 0; last_wr_cyc = -1; done_cyc = -1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    waited = 0;
    while (n_done == 0 && waited < 20000) begin
      @(negedge clk);
      waited++;
      if (extra_start && waited == 20) start = 1'b1;
      if (extra_start && waited == 21) start = 1'b0;
    end
    check(n_done != 0, "R6", {nm, " run finished"}, n_done, 1);
    repeat (30) @(negedge clk);
    for (int i = 0; i < 7; i++)
      check(rd_log[i] == i, "R1", {nm, " header read order"}, rd_log[i], i);
    bad_mem = 0;
    for (int i = 0; i < MEM_N; i++) if (mem[i] !== exp_mem[i]) bad_mem++;
    check(bad_mem == 0, "R2 R3 R4", {nm, " final memory words wrong"}, bad_mem, 0);
    bad_seq = 0;
    for (int i = 0; i < n_exp && i < n_wr; i++)
      if (act_wa[i] != exp_wa[i] || act_wd[i] !== exp_wd[i]) bad_seq++;
    check(n_wr == n_exp, "R5", {nm, " write count"}, n_wr, n_exp);
    check(bad_seq == 0, "R5", {nm, " write order mismatches"}, bad_seq, 0);
    check(n_done == 1, "R6 R8", {nm, " done pulses"}, n_done, 1);
    if (n_exp > 0)
      check(done_cyc == last_wr_cyc + 1, "R6", {nm, " done cycle"}, done_cyc, last_wr_cyc + 1);
    check(n_conf == 0, "R9", {nm, " read/write overlap"}, n_conf, 0);
    check(busy == 1'b0, "R8", {nm, " idle after run"}, busy, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    cyc = 0; n_wr = 0; n_rd = 0; n_done = 0; n_conf = 0;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !mem_rd_en && !mem_wr_en, "R7", "reset state quiet",
          {busy, done, mem_rd_en, mem_wr_en}, 0);

    build(3, 2, 4);  run("directed_h2", 1'b0);
    build(6, 1, 3);  run("wrap_h1", 1'b0);     // R4 frequent wrap
    build(1, 0, 2);  run("single_node", 1'b0); // R4 every step wraps
    build(0, 2, 4);  run("zero_rounds", 1'b0); // R7
    build(2, 2, 0);  run("zero_batch", 1'b0);  // R7
    build(3, 3, 5);  run("start_while_busy", 1'b1); // R8
    for (int k = 0; k < 4; k++) begin
      build(1 + int'($urandom % 5), 1 + int'($urandom % 4), 1 + int'($urandom % 8));
      run("random", 1'b0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule